// File: doc/BRIEF.md
# Receive Gate for Transmit/Receive Sample Alignment

This block sits between a free-running receive converter and the upstream sample stream to the host, and it also passes the host's downstream transmit samples on to the transmit converter. A session starts with the gate shut. Every receive sample that comes in is thrown away, so the upstream stream stays silent. The first transmit sample accepted from the host opens the gate. The receive sample taken on that same strobe becomes upstream sample zero. From then on, every strobe forwards one receive sample.

Because both directions are strobed by one shared sample enable, and both reach their outputs through exactly one register, upstream sample N and transmit sample N always belong to the same strobe. Host software can therefore match the two directions by stream index alone. A sticky error flag reports any broken continuity, whether a missing transmit sample while the gate is open or an upstream sample the host was not ready to take. An end-of-session pulse shuts the gate and clears the flag for the next session.

Top module: `rxg_aligner`

## Requirements
- R1: After reset, `gate_open`, `up_valid`, `dac_valid` and `err` are all 0.
- R2: While the gate is shut, a strobe without an accepted transmit sample produces no upstream output: `up_valid` stays 0 in the following cycle.
- R3: A strobe on which `tx_valid` is 1 and `session_end` is 0 opens the gate, and `gate_open` reads 1 in the next cycle.
- R4: On the strobe that opens the gate, `adc_data` is forwarded. In the next cycle `up_valid` is 1 with that value on `up_data`, in the same cycle as `dac_valid` carrying the first transmit sample, so both paths have one cycle of latency.
- R5: While the gate is open, every strobe without `session_end` gives `up_valid`=1 one cycle later, carrying that strobe's `adc_data`. In cycles that follow no forwarding strobe, `up_valid` is 0 and `up_data` holds its value.
- R6: `tx_ready` equals `smp_en` AND NOT `session_end`. Every accepted transmit sample appears on `dac_data` with `dac_valid`=1 in the next cycle. Otherwise `dac_valid` is 0 and `dac_data` holds its value.
- R7: Once open, the gate stays open until `session_end`. A `session_end` cycle shuts the gate, clears `err`, accepts no transmit sample and forwards nothing.
- R8: A strobe while the gate is open with `tx_valid`=0 (transmit underrun) sets `err` in the next cycle.
- R9: A cycle with `up_valid`=1 and `up_ready`=0 (upstream overflow) sets `err` in the next cycle.
- R10: `err` stays 1 until `session_end` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_en | input | 1 | Shared sample strobe for both converters |
| session_end | input | 1 | Ends the session: shuts the gate, clears the error |
| adc_data | input | W | Receive converter sample, valid when smp_en is 1 |
| tx_valid | input | 1 | Host transmit sample available |
| tx_data | input | W | Host transmit sample |
| tx_ready | output | 1 | Transmit sample taken this cycle |
| dac_valid | output | 1 | New sample on dac_data |
| dac_data | output | W | Sample for the transmit converter |
| up_valid | output | 1 | New sample on up_data for the host |
| up_data | output | W | Forwarded receive sample |
| up_ready | input | 1 | Host can take the upstream sample this cycle |
| gate_open | output | 1 | Gate state, 1 while receive samples are forwarded |
| err | output | 1 | Sticky underrun/overflow flag |

## Verification
The assertions check the cycle-to-cycle relations on every cycle. Upstream output stays silent while the gate is shut. The gate opens on the first accepted transmit sample, and the upstream and converter pulses on that opening strobe coincide. The gate holds until session end. The error flag is set by underrun and by overflow, stays set, and is cleared by session end. Only the bench's scenarios show the sample values: that the data forwarded is the receive sample of the same strobe, that index N upstream matches index N downstream across long random runs with sessions restarted, and that data outputs hold between strobes.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  typedef enum logic {
    GATE_SHUT = 1'b0,
    GATE_FWD  = 1'b1
  } gate_state_t;
endpackage

// File: rtl/rxg_rst_sync.sv
module rxg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/rxg_gate_fsm.sv
module rxg_gate_fsm
  import rxg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_take,
  input  logic session_end,
  output logic is_open
);
  gate_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_SHUT: if (tx_take)     state_d = GATE_FWD;
      GATE_FWD:  if (session_end) state_d = GATE_SHUT;
      default:                    state_d = GATE_SHUT;
    endcase
    if (session_end) state_d = GATE_SHUT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GATE_SHUT;
    else        state_q <= state_d;
  end

  assign is_open = (state_q == GATE_FWD);
endmodule

// File: rtl/rxg_sample_path.sv
module rxg_sample_path #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         vld,
  output logic [W-1:0] dout
);
  logic [W-1:0] data_q, data_d;
  logic         vld_q;

  always_comb begin
    data_d = data_q;
    if (load) data_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= load;
    end
  end

  assign vld  = vld_q;
  assign dout = data_q;
endmodule

// File: rtl/rxg_err_track.sv
module rxg_err_track (
  input  logic clk,
  input  logic rst_n,
  input  logic is_open,
  input  logic smp_en,
  input  logic tx_valid,
  input  logic session_end,
  input  logic up_valid,
  input  logic up_ready,
  output logic err
);
  logic err_q, err_d;
  logic underrun, overflow;

  always_comb begin
    underrun = is_open & smp_en & ~tx_valid;
    overflow = up_valid & ~up_ready;
    err_d    = err_q | underrun | overflow;
    if (session_end) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;
endmodule

// File: rtl/rxg_aligner.sv
module rxg_aligner #(
  parameter int W          = 16,
  parameter int SYNC_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_en,
  input  logic         session_end,
  input  logic [W-1:0] adc_data,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ready,
  output logic         dac_valid,
  output logic [W-1:0] dac_data,
  output logic         up_valid,
  output logic [W-1:0] up_data,
  input  logic         up_ready,
  output logic         gate_open,
  output logic         err
);
  logic rst_n_s;
  logic strobe_live;
  logic tx_take;
  logic fwd_take;
  logic is_open;

  rxg_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  assign strobe_live = smp_en & ~session_end;
  assign tx_take     = strobe_live & tx_valid;
  assign fwd_take    = strobe_live & (is_open | tx_valid);

  rxg_gate_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .tx_take     (tx_take),
    .session_end (session_end),
    .is_open     (is_open)
  );

  rxg_sample_path #(.W(W)) u_up (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (fwd_take),
    .din   (adc_data),
    .vld   (up_valid),
    .dout  (up_data)
  );

  rxg_sample_path #(.W(W)) u_dac (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (tx_take),
    .din   (tx_data),
    .vld   (dac_valid),
    .dout  (dac_data)
  );

  rxg_err_track u_err (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .is_open     (is_open),
    .smp_en      (smp_en),
    .tx_valid    (tx_valid),
    .session_end (session_end),
    .up_valid    (up_valid),
    .up_ready    (up_ready),
    .err         (err)
  );

  assign tx_ready  = strobe_live;
  assign gate_open = is_open;
endmodule

// File: rtl/rxg_aligner_chk.sv
module rxg_aligner_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_en,
  input logic session_end,
  input logic tx_valid,
  input logic up_valid,
  input logic up_ready,
  input logic dac_valid,
  input logic gate_open,
  input logic err
);
  assert_shut_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && !(smp_en && tx_valid)) |=> !up_valid);

  assert_first_tx_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && tx_valid && !session_end) |=> gate_open);

  assert_aligned_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && smp_en && tx_valid && !session_end) |=> (up_valid && dac_valid));

  assert_open_forwards_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && smp_en && !session_end) |=> up_valid);

  assert_gate_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && !session_end) |=> gate_open);

  assert_end_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    session_end |=> (!gate_open && !err && !up_valid && !dac_valid));

  assert_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && smp_en && !tx_valid && !session_end) |=> err);

  assert_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_ready && !session_end) |=> err);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !session_end) |=> err);
endmodule

bind rxg_aligner rxg_aligner_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .smp_en      (smp_en),
  .session_end (session_end),
  .tx_valid    (tx_valid),
  .up_valid    (up_valid),
  .up_ready    (up_ready),
  .dac_valid   (dac_valid),
  .gate_open   (gate_open),
  .err         (err)
);

// File: tb/sim_rxg_aligner.sv
module sim_rxg_aligner;
  localparam int W = 16;

  logic         clk;
  logic         rst_n;
  logic         smp_en;
  logic         session_end;
  logic [W-1:0] adc_data;
  logic         tx_valid;
  logic [W-1:0] tx_data;
  logic         tx_ready;
  logic         dac_valid;
  logic [W-1:0] dac_data;
  logic         up_valid;
  logic [W-1:0] up_data;
  logic         up_ready;
  logic         gate_open;
  logic         err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;
  string scen = "R1";

  logic         e_open, e_upv, e_dv, e_err;
  logic [W-1:0] e_upd, e_dd;

  rxg_aligner #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .session_end(session_end),
    .adc_data(adc_data), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .dac_valid(dac_valid), .dac_data(dac_data),
    .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
    .gate_open(gate_open), .err(err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (scenario %s) actual=%0h expected=%0h at cycle %0d",
               tag, scen, act, exp, cycles);
    end
  endtask

  function automatic logic f_ready(input logic se, input logic en);
    return se & ~en;
  endfunction

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic se, input logic tv, input logic [W-1:0] td,
                      input logic [W-1:0] ad, input logic rdy, input logic en);
    logic n_open, n_upv, n_dv, n_err;
    logic [W-1:0] n_upd, n_dd;
    smp_en = se; tx_valid = tv; tx_data = td; adc_data = ad;
    up_ready = rdy; session_end = en;
    #1;
    chk(tx_ready === f_ready(se, en), "R6", tx_ready, f_ready(se, en));
    @(posedge clk);
    n_upv  = se & ~en & (e_open | tv);
    n_upd  = n_upv ? ad : e_upd;
    n_dv   = se & tv & ~en;
    n_dd   = n_dv ? td : e_dd;
    n_open = en ? 1'b0 : (e_open | (se & tv));
    n_err  = en ? 1'b0 : (e_err | (e_open & se & ~tv) | (e_upv & ~rdy));
    e_open = n_open; e_upv = n_upv; e_upd = n_upd;
    e_dv = n_dv; e_dd = n_dd; e_err = n_err;
    @(negedge clk);
    chk(gate_open === e_open, "R3", gate_open, e_open);
    chk(up_valid  === e_upv,  "R5", up_valid,  e_upv);
    chk(up_data   === e_upd,  "R4", up_data,   e_upd);
    chk(dac_valid === e_dv,   "R6", dac_valid, e_dv);
    chk(dac_data  === e_dd,   "R6", dac_data,  e_dd);
    chk(err       === e_err,  "R10", err,      e_err);
  endtask

  initial begin
    while (!done && cycles < 150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d actual=hung expected=finished", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a0, t0;
    void'($urandom(32'd20240611));
    smp_en = 0; session_end = 0; adc_data = '0; tx_valid = 0; tx_data = '0; up_ready = 1;
    rst_n = 0;
    e_open = 0; e_upv = 0; e_dv = 0; e_err = 0; e_upd = '0; e_dd = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    scen = "R1";
    chk(gate_open === 1'b0, "R1", gate_open, 0);
    chk(up_valid  === 1'b0, "R1", up_valid, 0);
    chk(dac_valid === 1'b0, "R1", dac_valid, 0);
    chk(err       === 1'b0, "R1", err, 0);
    rst_n = 1;
    repeat (4) step(0, 0, '0, '0, 1, 0);

    // R2: gate shut, receive samples discarded
    scen = "R2";
    for (int i = 0; i < 30; i++) begin
      step(1'($urandom), 0, 16'($urandom), 16'($urandom), 1, 0);
      chk(up_valid === 1'b0, "R2", up_valid, 0);
    end

    // R3/R4: first transmit sample opens the gate and aligns index zero
    scen = "R3";
    a0 = 16'hA5C3; t0 = 16'h1234;
    step(1, 1, t0, a0, 1, 0);
    chk(gate_open === 1'b1, "R3", gate_open, 1);
    chk(up_valid === 1'b1 && up_data === a0, "R4", up_data, a0);
    chk(dac_valid === 1'b1 && dac_data === t0, "R4", dac_data, t0);

    // R5: continuous forwarding, strobe every other cycle
    scen = "R5";
    for (int i = 0; i < 40; i++) step(1'(i % 2 == 0), 1, 16'($urandom), 16'($urandom), 1, 0);
    chk(err === 1'b0, "R5", err, 0);

    // R7: session end closes gate and blocks the strobe in the same cycle
    scen = "R7";
    step(1, 1, 16'h0F0F, 16'hF0F0, 1, 1);
    chk(gate_open === 1'b0 && up_valid === 1'b0 && dac_valid === 1'b0, "R7",
        {gate_open, up_valid, dac_valid}, 0);
    step(1, 0, '0, 16'h5555, 1, 0);
    chk(up_valid === 1'b0, "R7", up_valid, 0);

    // R8: underrun while open
    scen = "R8";
    step(1, 1, 16'h0001, 16'h1111, 1, 0);
    step(0, 0, '0, '0, 1, 0);
    step(1, 0, '0, 16'h2222, 1, 0);
    chk(err === 1'b1, "R8", err, 1);
    repeat (5) step(1, 1, 16'($urandom), 16'($urandom), 1, 0);
    chk(err === 1'b1, "R10", err, 1);
    step(0, 0, '0, '0, 1, 1);
    chk(err === 1'b0, "R10", err, 0);

    // R9: overflow when host not ready
    scen = "R9";
    step(1, 1, 16'h0002, 16'h3333, 1, 0);
    step(0, 0, '0, '0, 0, 0);
    chk(err === 1'b1, "R9", err, 1);
    step(0, 0, '0, '0, 1, 1);

    // R4: long random mix with rare session restarts
    scen = "R4";
    for (int i = 0; i < 3000; i++)
      step(1'($urandom % 3 != 0), 1'($urandom % 8 != 0), 16'($urandom),
           16'($urandom), 1'($urandom % 10 != 0), 1'($urandom % 97 == 0));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule